// File: doc/BRIEF.md
# Oscillator Trim Register Write Slave

This block sits on a two-wire serial bus and accepts only write transfers. It sets one 8-bit trim value, which drives the load-capacitance control of a pullable crystal oscillator. A larger code adds more load capacitance and so lowers the oscillator frequency. Every code from 0x00 to 0xFF is legal. Both bus lines are oversampled by a system clock that runs at least 16 times faster than SCL. Each line passes through a two-flop synchronizer, and all bus events are taken from the synchronized copies.

A transfer opens with a start condition. The first byte carries the 7-bit device address and then the direction bit. The second byte loads an internal register pointer. Each data byte after that is written at the pointer, and the pointer then advances by one. Only a data byte that lands on pointer value 0x13 changes the trim value. That write also raises a one-cycle update strobe. The slave acknowledges a byte by asserting an open-drain enable, which pulls SDA low for the ninth clock period.

Top module: `trim_wire_slave`

## Requirements
- R1: While reset is active, and on the first cycle after it, `trim_o` is 0x00 and both `sda_oe_o` and `trim_upd_o` are 0.
- R2: A stop condition is SDA rising while SCL is high. It returns the slave to idle and releases `sda_oe_o`. Bus activity after it is ignored until the next start condition. A stop in the middle of a transfer leaves `trim_o` unchanged.
- R3: An acknowledged byte makes `sda_oe_o` go high after the eighth SCL falling edge. The enable stays high for the whole ninth SCL high phase and drops at the ninth falling edge. It never rises while SCL is high.
- R4: The first byte after a start condition carries the device address in bits 7..1, MSB first, and the direction in bit 0, where 0 means write. The slave responds only to address 0x69 with a write, which is the byte 0xD2. Any other first byte gets no acknowledge. After such a byte the slave drives nothing and changes nothing until the next start condition.
- R5: The second byte loads the register pointer. A data byte written while the pointer is 0x13 is loaded into `trim_o`, whatever its value from 0x00 to 0xFF.
- R6: After each data byte the pointer advances by one. A burst that starts at 0x13 therefore updates the trim value only with its first data byte. A burst that starts at 0x12 updates it only with its second data byte.
- R7: A data byte written while the pointer is not 0x13 is acknowledged. It does not change `trim_o` and does not pulse `trim_upd_o`.
- R8: A start condition at any point, including partway through a byte, releases SDA and restarts device-address reception.
- R9: Data bits are taken only from SCL high phases. SDA changes while SCL is low have no effect on the received value.
- R10: `trim_upd_o` pulses for exactly one cycle for each write at pointer 0x13. `trim_o` changes only in a cycle in which `trim_upd_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| trim_o | output | 8 | Oscillator trim code |
| trim_upd_o | output | 1 | One-cycle strobe when `trim_o` is written |

## Verification
The bench sends bursts that start below and at the trim address. A slave without auto-increment would load the wrong data byte into the trim register. The bench also sends a read-direction first byte and a wrong device address. A slave that checked only the address bits, or that stopped ignoring the bus too early, would acknowledge later bytes or corrupt the trim value. The bench cuts a transfer with a repeated start partway through a data byte, and cuts another with a stop right after the pointer byte. A slave that kept its bit count across the restart would misalign the next frame. SDA is driven to the wrong level early in every SCL low phase, so a receiver that sampled during the low phase would capture the wrong bits.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_ACK   = 2'd2,
    PH_SKIP  = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    FLD_DEV  = 2'd0,
    FLD_REG  = 2'd1,
    FLD_DATA = 2'd2
  } field_t;

  // First byte selects this slave only for a matching address with a write.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                    input logic [ADDR_W-1:0] dev);
    return (rx[BYTE_W-1:1] == dev) && (rx[0] == 1'b0);
  endfunction

  function automatic logic [BYTE_W-1:0] ptr_next(input logic [BYTE_W-1:0] p);
    return p + BYTE_W'(1);
  endfunction

  function automatic field_t field_after(input field_t f);
    return (f == FLD_DEV) ? FLD_REG : FLD_DATA;
  endfunction
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[0] <= RST_VAL;
          else        pipe[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/tws_bus_events.sv
module tws_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  // SDA moving while SCL stays high is a frame condition, not data.
  assign start_evt = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_evt  = scl_q & scl_s & ~sda_q & sda_s;
  assign scl_rise  = ~scl_q & scl_s;
  assign scl_fall  = scl_q & ~scl_s;
endmodule

// File: rtl/tws_xfer_fsm.sv
module tws_xfer_fsm
  import tws_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  output logic              ack_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output phase_t            phase_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_t            phase;
  field_t            field;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] ptr;
  logic              byte_done;

  assign byte_done = scl_fall && (bit_cnt == FULL);
  assign phase_o   = phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= PH_IDLE;
      field   <= FLD_DEV;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      ack_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        phase   <= PH_SHIFT;
        field   <= FLD_DEV;
        bit_cnt <= '0;
        ack_oe  <= 1'b0;
      end else if (stop_evt) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        ack_oe  <= 1'b0;
      end else begin
        case (phase)
          PH_SHIFT: begin
            if (scl_rise && bit_cnt != FULL) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + CNT_W'(1);
            end else if (byte_done) begin
              bit_cnt <= '0;
              case (field)
                FLD_DEV: begin
                  if (addr_hit(shreg, DEV_ADDR)) begin
                    phase  <= PH_ACK;
                    ack_oe <= 1'b1;
                  end else begin
                    phase  <= PH_SKIP;
                  end
                end
                FLD_REG: begin
                  ptr    <= shreg;
                  phase  <= PH_ACK;
                  ack_oe <= 1'b1;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr_next(ptr);
                  phase   <= PH_ACK;
                  ack_oe  <= 1'b1;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              ack_oe <= 1'b0;
              phase  <= PH_SHIFT;
              field  <= field_after(field);
            end
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/trim_wire_slave.sv
module trim_wire_slave
  import tws_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h69,
  parameter logic [BYTE_W-1:0] TRIM_ADDR   = 8'h13,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] trim_o,
  output logic              trim_upd_o
);
  logic              scl_s, sda_s;
  logic              start_evt, stop_evt, scl_rise, scl_fall;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data;
  logic              trim_hit;
  phase_t            phase;

  tws_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout ({scl_s, sda_s})
  );

  tws_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  tws_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .ack_oe   (sda_oe_o),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .phase_o  (phase)
  );

  assign trim_hit = wr_en && (wr_addr == TRIM_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trim_o     <= '0;
      trim_upd_o <= 1'b0;
    end else begin
      trim_upd_o <= trim_hit;
      if (trim_hit) trim_o <= wr_data;
    end
endmodule

// File: rtl/tws_checker.sv
module tws_checker
  import tws_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              sda_oe,
  input logic              trim_upd,
  input logic [BYTE_W-1:0] trim,
  input phase_t            phase
);
  assert_upd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trim_upd |=> !trim_upd);

  assert_trim_only_on_upd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trim != $past(trim)) |-> trim_upd);

  assert_ack_rise_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && phase == PH_IDLE));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && phase == PH_SHIFT));

  assert_skip_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> (!sda_oe && !trim_upd));

  assert_upd_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trim_upd |-> sda_oe);
endmodule

bind trim_wire_slave tws_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .sda_oe   (sda_oe_o),
  .trim_upd (trim_upd_o),
  .trim     (trim_o),
  .phase    (phase)
);

// File: tb/trim_wire_slave_tb_top.sv
module trim_wire_slave_tb_top;
  localparam int Q = 10;   // quarter SCL period in system clocks (SCL = clk/40)

  typedef struct packed {
    logic [7:0] first_b;
    logic [7:0] reg_b;
    logic [7:0] d0;
    logic [7:0] d1;
    logic [1:0] ndata;
    logic       dev_ack;
    logic [7:0] exp_trim;
    logic [1:0] exp_upd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'hD2, 8'h13, 8'hA5, 8'h00, 2'd1, 1'b1, 8'hA5, 2'd1},  // R5 direct write
    '{8'hD2, 8'h13, 8'h3C, 8'h77, 2'd2, 1'b1, 8'h3C, 2'd1},  // R6 burst from 0x13
    '{8'hD2, 8'h12, 8'h11, 8'h5A, 2'd2, 1'b1, 8'h5A, 2'd1},  // R6 burst from 0x12
    '{8'hD2, 8'h40, 8'hEE, 8'h00, 2'd1, 1'b1, 8'h5A, 2'd0},  // R7 other pointer
    '{8'hD3, 8'h13, 8'h99, 8'h00, 2'd1, 1'b0, 8'h5A, 2'd0},  // R4 read direction
    '{8'hD4, 8'h13, 8'h99, 8'h00, 2'd1, 1'b0, 8'h5A, 2'd0},  // R4 wrong address
    '{8'hD2, 8'h13, 8'hFF, 8'h00, 2'd1, 1'b1, 8'hFF, 2'd1},  // R5 top code
    '{8'hD2, 8'h13, 8'h00, 8'h00, 2'd1, 1'b1, 8'h00, 2'd1}   // R5 bottom code
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe_o, trim_upd_o;
  logic [7:0] trim_o;
  wire  sda_line = sda_m & ~sda_oe_o;

  int checks = 0;
  int fails  = 0;
  int upd_cnt = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n && trim_upd_o) upd_cnt <= upd_cnt + 1;

  trim_wire_slave dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe_o),
    .trim_o    (trim_o),
    .trim_upd_o(trim_upd_o)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    sda_m = 1'b1; wait_clk(2 * Q);
  endtask

  // R9: each bit is first driven to the wrong level during SCL low.
  task automatic send_bit(input logic b);
    sda_m = ~b;   wait_clk(Q / 2);
    sda_m = b;    wait_clk(Q / 2);
    scl = 1'b1;   wait_clk(2 * Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    acked = ~sda_line;
    wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic run_all();
    logic ack;
    int   base;
    logic [7:0] trim_before;
    wait_clk(3);
    // R1 reset state
    check(trim_o == 8'h00, "R1 trim", trim_o, 0);
    check(sda_oe_o == 1'b0 && trim_upd_o == 1'b0, "R1 oe/upd", {sda_oe_o, trim_upd_o}, 0);
    rst_n = 1'b1;
    wait_clk(1);
    check(trim_o == 8'h00 && sda_oe_o == 1'b0, "R1 after release", trim_o, 0);
    wait_clk(10);

    for (int v = 0; v < NV; v++) begin
      base = upd_cnt;
      bus_start();
      send_byte(VECS[v].first_b, ack);
      check(ack == VECS[v].dev_ack, $sformatf("R3 R4 v%0d first-byte ack", v), ack, VECS[v].dev_ack);
      send_byte(VECS[v].reg_b, ack);
      check(ack == VECS[v].dev_ack, $sformatf("R3 R4 v%0d pointer ack", v), ack, VECS[v].dev_ack);
      send_byte(VECS[v].d0, ack);
      check(ack == VECS[v].dev_ack, $sformatf("R3 R7 v%0d data0 ack", v), ack, VECS[v].dev_ack);
      if (VECS[v].ndata == 2'd2) begin
        send_byte(VECS[v].d1, ack);
        check(ack == VECS[v].dev_ack, $sformatf("R6 v%0d data1 ack", v), ack, VECS[v].dev_ack);
      end
      bus_stop();
      check(sda_oe_o == 1'b0, $sformatf("R2 v%0d oe after stop", v), sda_oe_o, 0);
      check(trim_o == VECS[v].exp_trim, $sformatf("R5 R6 R9 v%0d trim", v), trim_o, VECS[v].exp_trim);
      check(upd_cnt - base == int'(VECS[v].exp_upd), $sformatf("R10 v%0d strobe cycles", v),
            upd_cnt - base, VECS[v].exp_upd);
    end

    // R8: repeated start partway through a data byte
    trim_before = trim_o;
    base = upd_cnt;
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h13, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    check(trim_o == trim_before, "R8 trim after partial byte", trim_o, trim_before);
    bus_start();
    send_byte(8'hD2, ack);
    check(ack == 1'b1, "R8 ack after repeated start", ack, 1);
    send_byte(8'h13, ack);
    send_byte(8'h66, ack);
    bus_stop();
    check(trim_o == 8'h66, "R8 trim after restart", trim_o, 8'h66);
    check(upd_cnt - base == 1, "R10 strobe after restart", upd_cnt - base, 1);

    // R2: stop right after the pointer, then stray clocks while idle
    base = upd_cnt;
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h13, ack);
    bus_stop();
    send_byte(8'hD2, ack);
    check(ack == 1'b0, "R2 no ack while idle", ack, 0);
    send_byte(8'h13, ack);
    send_byte(8'h24, ack);
    check(trim_o == 8'h66, "R2 trim unchanged", trim_o, 8'h66);
    check(upd_cnt - base == 0, "R2 no strobe", upd_cnt - base, 0);
    bus_stop();

    // R4: bytes after a rejected address stay ignored
    bus_start();
    send_byte(8'h52, ack);
    send_byte(8'hD2, ack);
    check(ack == 1'b0, "R4 ignored until start", ack, 0);
    bus_stop();
  endtask

  initial begin
    fork
      run_all();
      begin
        wait_clk(150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule